// File: doc/BRIEF.md
# Three-Mode Configurable Logic Cell

This block is one programmable cell of a logic fabric. A static configuration word selects how the four data inputs, the carry input and the cascade input are used. The mode can be a single 4-input lookup table, an adder-style pair of 3-input tables (result plus carry), or a counter stage whose feedback comes from the cell's own register. The table result is combined with the incoming cascade value through an AND or an OR gate, chosen by configuration. The combined value leaves on the cascade output and also feeds the cell's register.

The register has three controls. An active-low asynchronous clear acts at once. The synchronous clear and the synchronous load are shared control lines. Both override the cascade path, and the clear wins over the load. The cell output comes either from the register or straight from the combined value. Cells are chained through carry and cascade to build wide decoders, adders and counters.

Top module: `logic_cell`

## Requirements
- R1: Normal mode (`cfg_mode`=0) returns bit `cfg_lut[idx]`, where idx = {din[3], s, din[1], din[0]} (din[0] is the least significant bit). s is `cin` when `cfg_use_cin`=1 and `din[2]` otherwise. In this mode `cout` is 0.
- R2: In every mode `cas_out` is the table result ANDed with `cas_in` when `cfg_casc_or`=0, and ORed with it when `cfg_casc_or`=1.
- R3: Arithmetic mode (`cfg_mode`=1) uses k = {cin, din[1], din[0]}. The result bit is `cfg_lut[k]` and `cout` is `cfg_lut[8+k]`.
- R4: Counter mode (`cfg_mode`=2) uses k = {cin, din[1], q}, where q is the register value and din[1] is the direction. `cout` = `cfg_lut[8+k]` whatever the enable. When `din[0]`=1 and neither clear nor load is active, the register takes the cascade-combined value of `cfg_lut[k]` at the clock edge.
- R5: In counter mode with `din[0]`=0 and no clear or load, the register keeps its value across clock edges.
- R6: When `sload`=1 and `sclr`=0, the register takes `din[2]` at the clock edge in any mode, whatever the cascade value.
- R7: When `sclr`=1 the register becomes 0 at the clock edge, even when `sload`=1 in the same cycle.
- R8: `rst_n`=0 clears the register at once, without waiting for a clock edge.
- R9: With `cfg_registered`=1, `le_out` shows the register. With `cfg_registered`=0, it shows `cas_out` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| cfg_mode | input | 2 | 0 normal, 1 arithmetic, 2 counter (3 acts as normal) |
| cfg_lut | input | 16 | Table mask; in 3-input modes the low half is the result table and the high half the carry table |
| cfg_use_cin | input | 1 | Normal mode: carry input replaces din[2] in the table index |
| cfg_casc_or | input | 1 | Cascade gate: 0 AND, 1 OR |
| cfg_registered | input | 1 | Output from register (1) or combinational (0) |
| din | input | 4 | Data inputs; counter mode: din[0] enable, din[1] up/down, din[2] load data |
| cin | input | 1 | Carry input |
| cas_in | input | 1 | Cascade input |
| sclr | input | 1 | Shared synchronous clear |
| sload | input | 1 | Shared synchronous load (data from din[2]) |
| le_out | output | 1 | Cell output |
| cout | output | 1 | Carry output |
| cas_out | output | 1 | Cascade output |

## Verification
Three register actions can land on the same edge: synchronous clear, synchronous load and a counter step. The bench arms them together, with load data 1 and the count enabled, to show that the clear alone decides the result. It then asserts load together with a forcing cascade value (AND with 0), to show that the loaded bit beats the combined path. A further test drops the asynchronous clear in the middle of a cycle. The output is judged before the next edge, so the clear is seen acting without the clock.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int LC_INPUTS = 4;
  localparam int LC_MASK_W = 1 << LC_INPUTS;
  localparam int LC_HALF_W = LC_MASK_W / 2;
  localparam int LC_SUB_W  = LC_INPUTS - 1;

  typedef enum logic [1:0] {
    LC_NORMAL = 2'd0,
    LC_ARITH  = 2'd1,
    LC_COUNT  = 2'd2,
    LC_SPARE  = 2'd3
  } lc_mode_e;

  // pick one bit of the full table
  function automatic logic pick_full(input logic [LC_MASK_W-1:0] mask,
                                     input logic [LC_INPUTS-1:0] idx);
    return mask[idx];
  endfunction

  // pick one bit of the lower (result) or upper (carry) half table
  function automatic logic pick_half(input logic [LC_MASK_W-1:0] mask,
                                     input logic [LC_SUB_W-1:0] idx,
                                     input logic upper);
    logic [LC_INPUTS-1:0] full;
    full = {upper, idx};
    return mask[full];
  endfunction

  function automatic logic cascade_join(input logic f, input logic cas,
                                        input logic use_or);
    return use_or ? (f | cas) : (f & cas);
  endfunction
endpackage

// File: rtl/lcell_lut_eval.sv
module lcell_lut_eval
  import lcell_pkg::*;
(
  input  lc_mode_e                mode,
  input  logic [LC_MASK_W-1:0]    mask,
  input  logic [LC_INPUTS-1:0]    din,
  input  logic                    cin,
  input  logic                    use_cin,
  input  logic                    q_fb,
  output logic                    func_bit,
  output logic                    carry_bit,
  output logic                    split_mode
);
  logic [LC_INPUTS-1:0] full_idx;
  logic [LC_SUB_W-1:0]  half_idx;
  logic                 low_src;

  always_comb begin
    full_idx    = din;
    full_idx[2] = use_cin ? cin : din[2];
    low_src     = (mode == LC_COUNT) ? q_fb : din[0];
    half_idx    = {cin, din[1], low_src};
    split_mode  = (mode == LC_ARITH) || (mode == LC_COUNT);
  end

  always_comb begin
    if (split_mode) begin
      func_bit  = pick_half(mask, half_idx, 1'b0);
      carry_bit = pick_half(mask, half_idx, 1'b1);
    end else begin
      func_bit  = pick_full(mask, full_idx);
      carry_bit = 1'b0;
    end
  end
endmodule

// File: rtl/lcell_cascade.sv
module lcell_cascade
  import lcell_pkg::*;
(
  input  logic func_bit,
  input  logic cas_in,
  input  logic use_or,
  output logic joined
);
  always_comb joined = cascade_join(func_bit, cas_in, use_or);
endmodule

// File: rtl/lcell_reg.sv
module lcell_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic sclr,
  input  logic sload,
  input  logic load_bit,
  input  logic count_mode,
  input  logic count_en,
  input  logic next_bit,
  output logic q,
  output logic clr_take,
  output logic load_take,
  output logic hold_take
);
  logic d;

  always_comb begin
    clr_take  = sclr;
    load_take = sload & ~sclr;
    hold_take = count_mode & ~count_en & ~sclr & ~sload;
    if (clr_take)       d = 1'b0;
    else if (load_take) d = load_bit;
    else if (hold_take) d = q;
    else                d = next_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import lcell_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_mode,
  input  logic [LC_MASK_W-1:0] cfg_lut,
  input  logic                 cfg_use_cin,
  input  logic                 cfg_casc_or,
  input  logic                 cfg_registered,
  input  logic [LC_INPUTS-1:0] din,
  input  logic                 cin,
  input  logic                 cas_in,
  input  logic                 sclr,
  input  logic                 sload,
  output logic                 le_out,
  output logic                 cout,
  output logic                 cas_out
);
  lc_mode_e mode;
  logic     func_bit, carry_bit, split_mode, joined;
  logic     reg_q, clr_take, load_take, hold_take, count_mode;

  assign mode       = lc_mode_e'(cfg_mode);
  assign count_mode = (mode == LC_COUNT);

  lcell_lut_eval u_lut (
    .mode(mode), .mask(cfg_lut), .din(din), .cin(cin),
    .use_cin(cfg_use_cin), .q_fb(reg_q),
    .func_bit(func_bit), .carry_bit(carry_bit), .split_mode(split_mode)
  );

  lcell_cascade u_cas (
    .func_bit(func_bit), .cas_in(cas_in), .use_or(cfg_casc_or), .joined(joined)
  );

  lcell_reg u_reg (
    .clk(clk), .rst_n(rst_n), .sclr(sclr), .sload(sload),
    .load_bit(din[2]), .count_mode(count_mode), .count_en(din[0]),
    .next_bit(joined), .q(reg_q),
    .clr_take(clr_take), .load_take(load_take), .hold_take(hold_take)
  );

  assign cas_out = joined;
  assign cout    = carry_bit;
  assign le_out  = cfg_registered ? reg_q : joined;
endmodule

// File: rtl/logic_cell_chk.sv
module logic_cell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode,
  input logic       cfg_casc_or,
  input logic [3:0] din,
  input logic       cas_in,
  input logic       cas_out,
  input logic       sclr,
  input logic       sload,
  input logic       reg_q
);
  // R7: clear wins at the edge, load ignored
  assert_sclr_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sclr |=> (reg_q == 1'b0));

  // R6: load takes din[2]
  assert_sload_takes_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sload && !sclr) |=> (reg_q == $past(din[2])));

  // R5: counter holds when disabled
  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd2 && !din[0] && !sclr && !sload) |=> $stable(reg_q));

  // R2: AND cascade with low input forces low
  assert_and_cascade_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_casc_or && !cas_in) |-> !cas_out);

  // R2: OR cascade with high input forces high
  assert_or_cascade_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_casc_or && cas_in) |-> cas_out);
endmodule

bind logic_cell logic_cell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_casc_or(cfg_casc_or),
  .din(din), .cas_in(cas_in), .cas_out(cas_out), .sclr(sclr),
  .sload(sload), .reg_q(reg_q)
);

// File: tb/test_logic_cell.sv
module test_logic_cell;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [15:0] cfg_lut = 16'h0;
  logic        cfg_use_cin = 1'b0, cfg_casc_or = 1'b0, cfg_registered = 1'b1;
  logic [3:0]  din = 4'h0;
  logic        cin = 1'b0, cas_in = 1'b1, sclr = 1'b0, sload = 1'b0;
  logic        le_out, cout, cas_out;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  logic_cell i_logic_cell (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_lut(cfg_lut),
    .cfg_use_cin(cfg_use_cin), .cfg_casc_or(cfg_casc_or),
    .cfg_registered(cfg_registered), .din(din), .cin(cin), .cas_in(cas_in),
    .sclr(sclr), .sload(sload), .le_out(le_out), .cout(cout), .cas_out(cas_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R8 reset output", le_out, 1'b0);
    chk("R1 reset cout", cout, 1'b0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_normal();
    @(negedge clk);
    cfg_mode = 2'd0; cfg_registered = 1'b0; cfg_casc_or = 1'b0; cas_in = 1'b1;
    cfg_lut = 16'h6996; cfg_use_cin = 1'b0; cin = 1'b0;
    for (int v = 0; v < 16; v++) begin
      din = v[3:0]; #1;
      chk("R1 parity", le_out, ^v[3:0]);
      chk("R1 cout zero", cout, 1'b0);
    end
    // table selects idx bit 2 only
    cfg_lut = 16'hF0F0; cfg_use_cin = 1'b1;
    din = 4'b0000; cin = 1'b1; #1; chk("R1 cin replaces din2", le_out, 1'b1);
    din = 4'b0100; cin = 1'b0; #1; chk("R1 din2 ignored", le_out, 1'b0);
    cfg_use_cin = 1'b0; #1; chk("R1 din2 used", le_out, 1'b1);
  endtask

  task automatic t_cascade();
    cfg_mode = 2'd0; cfg_registered = 1'b0;
    for (int f = 0; f < 2; f++)
      for (int p = 0; p < 2; p++)
        for (int c = 0; c < 2; c++) begin
          cfg_lut = f[0] ? 16'hFFFF : 16'h0000;
          cfg_casc_or = p[0]; cas_in = c[0]; #1;
          chk("R2 cascade", cas_out, p[0] ? (f[0] | c[0]) : (f[0] & c[0]));
        end
  endtask

  task automatic t_arith();
    cfg_mode = 2'd1; cfg_registered = 1'b0; cfg_casc_or = 1'b0; cas_in = 1'b1;
    cfg_lut = 16'hE896;
    for (int v = 0; v < 8; v++) begin
      din = {2'b00, v[1], v[0]}; cin = v[2]; #1;
      chk("R3 sum", le_out, v[0] ^ v[1] ^ v[2]);
      chk("R3 carry", cout, (v[0] + v[1] + v[2]) > 1);
    end
    cas_in = 1'b0; din = 4'b0001; cin = 1'b0; #1;
    chk("R2 arith cascade forced", le_out, 1'b0);
    chk("R3 carry beside cascade", cout, 1'b0);
    din = 4'b0011; #1; chk("R3 carry with cascade low", cout, 1'b1);
    cas_in = 1'b1;
  endtask

  task automatic t_counter();
    logic q_exp;
    @(negedge clk);
    cfg_mode = 2'd2; cfg_registered = 1'b1; cfg_casc_or = 1'b0; cas_in = 1'b1;
    cfg_lut = 16'h905A; sclr = 1'b1; din = 4'b0000; cin = 1'b0;
    @(negedge clk); sclr = 1'b0;
    q_exp = 1'b0;
    din = 4'b0011; cin = 1'b1;            // enable, up
    for (int i = 0; i < 4; i++) begin
      #1; chk("R4 up carry", cout, q_exp & cin);
      @(posedge clk); q_exp = q_exp ^ cin; #1;
      chk("R4 count step", le_out, q_exp);
      @(negedge clk);
    end
    din = 4'b0001;                        // down
    for (int i = 0; i < 2; i++) begin
      #1; chk("R4 down carry", cout, ~q_exp & cin);
      @(posedge clk); q_exp = q_exp ^ cin; #1;
      chk("R4 down step", le_out, q_exp);
      @(negedge clk);
    end
    din = 4'b0011; cin = 1'b0;
    @(posedge clk); #1; chk("R4 no carry in keeps bit", le_out, q_exp);
    @(negedge clk);
    // force register to 1, then hold
    sload = 1'b1; din = 4'b0100; @(negedge clk); sload = 1'b0;
    din = 4'b0010; cin = 1'b1; q_exp = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1; chk("R4 carry while held", cout, q_exp & cin);
      @(posedge clk); #1; chk("R5 hold", le_out, q_exp);
      @(negedge clk);
    end
  endtask

  task automatic t_load_clear();
    @(negedge clk);
    cfg_mode = 2'd0; cfg_registered = 1'b1; cfg_lut = 16'h0000;
    cfg_casc_or = 1'b0; cas_in = 1'b0;
    sload = 1'b1; din = 4'b0100;
    @(posedge clk); #1; chk("R6 load beats cascade", le_out, 1'b1);
    @(negedge clk); din = 4'b0000;
    @(posedge clk); #1; chk("R6 load zero", le_out, 1'b0);
    @(negedge clk); din = 4'b0100;
    @(posedge clk); #1; chk("R6 reload one", le_out, 1'b1);
    @(negedge clk);
    cfg_mode = 2'd2; cfg_lut = 16'h905A; cas_in = 1'b1; cin = 1'b1;
    sclr = 1'b1; sload = 1'b1; din = 4'b0111;
    @(posedge clk); #1; chk("R7 clear beats load and count", le_out, 1'b0);
    @(negedge clk); sclr = 1'b0; sload = 1'b0; din = 4'b0000;
  endtask

  task automatic t_async();
    @(negedge clk);
    sload = 1'b1; din = 4'b0100;
    @(negedge clk); sload = 1'b0; din = 4'b0000;
    #1; chk("R6 preset for async", le_out, 1'b1);
    rst_n = 1'b0; #0.5;
    chk("R8 async clear before edge", le_out, 1'b0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_regsel();
    @(negedge clk);
    cfg_mode = 2'd0; cfg_lut = 16'h6996; cfg_casc_or = 1'b0; cas_in = 1'b1;
    cfg_use_cin = 1'b0; cfg_registered = 1'b1; din = 4'b0000;
    @(negedge clk); din = 4'b0001; #1;
    chk("R9 registered waits", le_out, 1'b0);
    @(posedge clk); #1; chk("R9 registered updates", le_out, 1'b1);
    @(negedge clk); cfg_registered = 1'b0; din = 4'b0011; #1;
    chk("R9 combinational now", le_out, 1'b0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_cascade();
    t_arith();
    t_counter();
    t_load_clear();
    t_async();
    t_regsel();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule